// File: doc/BRIEF.md
# Lockable Peripheral Access Controller

This block holds the access policy for six peripheral slots and answers, in the same cycle, whether a given transaction to one of those slots may proceed. The policy lives in three byte-wide registers. Each register carries two slots, and each slot is a 3-bit policy code with a lock bit beside it. Software programs the registers through a small byte bus. Once a slot's lock bit is set, that slot's code is frozen until the next system reset. Any write that reaches a register with a set lock is answered with a bus error.

The checker side is purely combinational. It takes a slot index, the privilege of the requester (supervisor or user) and the direction (read or write). It looks up the slot's code and drives exactly one of grant or deny. The codes treat supervisor and user unequally: several codes open a slot to the supervisor while shutting user code out completely.

Top module: `periph_access_ctrl`

## Requirements
- R1: After reset every register reads 0x00. Every slot then holds code 000, so a supervisor request is granted and a user request is denied.
- R2: The registers answer at byte addresses 0x24, 0x25 and 0x26. In each register, bits 2:0 are the code of the even slot (2n), bit 3 is its lock, bits 6:4 are the code of the odd slot (2n+1), and bit 7 is its lock. A read returns the current contents in the same cycle and never raises `reg_err`.
- R3: A write to a register with no lock set loads all eight bits at the clock edge and raises no error. The new value is visible from the next cycle.
- R4: A write to a register in which either lock bit is set raises `reg_err` in the cycle of the write. Every locked slot keeps its code and its lock bit.
- R5: In a register where only one slot is locked, a write that errors still loads the code and lock bit of the unlocked slot.
- R6: No write can clear a lock bit. Only reset returns it to 0, after which the register accepts writes again without error.
- R7: One write may set a slot's lock and its code together, provided the slot was unlocked. The lock guards the slot from the following cycle.
- R8: Permissions per code, given as supervisor/user: 000 RW/none, 001 R/none, 010 R/R, 011 R/none, 100 RW/RW, 101 RW/R, 110 RW/RW, 111 none/none. A write under a read-only permission is denied, and any access under "none" is denied.
- R9: `chk_grant` and `chk_deny` are always complementary and follow the checker inputs combinationally. A slot index of 6 or 7 is always denied.
- R10: Bus accesses to addresses outside 0x24 to 0x26 raise no error, read back 0x00 and change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, the only way to clear locks |
| reg_sel | input | 1 | Register bus access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte address of the access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when not a decoded read |
| reg_err | output | 1 | Error response for a write to a locked register |
| chk_idx | input | 3 | Slot index of the transaction to judge |
| chk_super | input | 1 | 1 = supervisor, 0 = user |
| chk_write | input | 1 | 1 = write, 0 = read |
| chk_grant | output | 1 | Transaction allowed |
| chk_deny | output | 1 | Transaction refused |

## Verification
Several properties are checked on every cycle. Lock bits never fall while reset is high. A locked slot's code never changes. Reads never error, and errors occur only on decoded writes. Grant and deny always oppose each other. Out-of-range indices and code 111 always deny, the fully open codes always grant, and user writes under restrictive codes always deny. Some behaviour can only be shown by the bench's scenarios. These are the exact eight-bit result of a partially locked write, the one-write lock-and-load, the clearing of locks by reset, the silence of out-of-range addresses, and a full sweep of every code in every slot against every privilege and direction.

// File: rtl/pac_pkg.sv
package pac_pkg;

  localparam int unsigned CODE_W        = 3;
  localparam int unsigned SLOT_W        = CODE_W + 1;
  localparam int unsigned SLOTS_PER_REG = 2;
  localparam int unsigned REG_W         = SLOTS_PER_REG * SLOT_W;

  typedef enum logic [CODE_W-1:0] {
    POL_SUP_RW        = 3'd0,
    POL_SUP_RO_A      = 3'd1,
    POL_BOTH_RO       = 3'd2,
    POL_SUP_RO_B      = 3'd3,
    POL_BOTH_RW_A     = 3'd4,
    POL_SUP_RW_USR_RO = 3'd5,
    POL_BOTH_RW_B     = 3'd6,
    POL_NONE          = 3'd7
  } pac_code_e;

  typedef struct packed {
    logic              lock;
    logic [CODE_W-1:0] code;
  } pac_slot_t;

  typedef struct packed {
    logic sup_rd;
    logic sup_wr;
    logic usr_rd;
    logic usr_wr;
  } pac_perm_t;

  // Translate a policy code into its four individual permissions.
  function automatic pac_perm_t policy_perm(input logic [CODE_W-1:0] code);
    pac_perm_t p;
    p = '0;
    case (pac_code_e'(code))
      POL_SUP_RW:        p = '{sup_rd: 1'b1, sup_wr: 1'b1, usr_rd: 1'b0, usr_wr: 1'b0};
      POL_SUP_RO_A:      p = '{sup_rd: 1'b1, sup_wr: 1'b0, usr_rd: 1'b0, usr_wr: 1'b0};
      POL_BOTH_RO:       p = '{sup_rd: 1'b1, sup_wr: 1'b0, usr_rd: 1'b1, usr_wr: 1'b0};
      POL_SUP_RO_B:      p = '{sup_rd: 1'b1, sup_wr: 1'b0, usr_rd: 1'b0, usr_wr: 1'b0};
      POL_BOTH_RW_A:     p = '{sup_rd: 1'b1, sup_wr: 1'b1, usr_rd: 1'b1, usr_wr: 1'b1};
      POL_SUP_RW_USR_RO: p = '{sup_rd: 1'b1, sup_wr: 1'b1, usr_rd: 1'b1, usr_wr: 1'b0};
      POL_BOTH_RW_B:     p = '{sup_rd: 1'b1, sup_wr: 1'b1, usr_rd: 1'b1, usr_wr: 1'b1};
      default:           p = '0;
    endcase
    return p;
  endfunction

  // Pick the permission that applies to one privilege and direction.
  function automatic logic perm_allows(input pac_perm_t p, input logic sup,
                                       input logic wr);
    logic ok;
    if (sup) ok = wr ? p.sup_wr : p.sup_rd;
    else     ok = wr ? p.usr_wr : p.usr_rd;
    return ok;
  endfunction

endpackage

// File: rtl/pac_addr_decode.sv
module pac_addr_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h24,
  parameter int unsigned NUM_REGS  = 3,
  parameter int unsigned REG_IDX_W = 2
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic [REG_IDX_W-1:0] reg_idx
);

  logic [ADDR_W-1:0] ofs;

  always_comb begin
    ofs     = addr - BASE;
    hit     = (addr >= BASE) && (int'(ofs) < int'(NUM_REGS));
    reg_idx = ofs[REG_IDX_W-1:0];
  end

endmodule

// File: rtl/pac_policy_reg.sv
module pac_policy_reg
  import pac_pkg::*;
#(
  parameter int unsigned SLOTS = SLOTS_PER_REG
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SLOTS*SLOT_W-1:0] wdata,
  output pac_slot_t [SLOTS-1:0]   slots_o,
  output logic                    locked_any_o
);

  pac_slot_t [SLOTS-1:0] slot_q;

  // Each slot is its own write-once field: a set lock blocks only that slot.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (wr_en && !slot_q[s].lock) begin
        slot_q[s] <= pac_slot_t'(wdata[s*SLOT_W +: SLOT_W]);
      end
    end
  end

  always_comb begin
    locked_any_o = 1'b0;
    for (int s = 0; s < int'(SLOTS); s++) begin
      locked_any_o = locked_any_o | slot_q[s].lock;
    end
  end

  assign slots_o = slot_q;

endmodule

// File: rtl/pac_slot_check.sv
module pac_slot_check
  import pac_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned IDX_W     = 3
) (
  input  pac_slot_t [NUM_SLOTS-1:0] slots,
  input  logic [IDX_W-1:0]          idx,
  input  logic                      sup,
  input  logic                      wr,
  output logic [CODE_W-1:0]         sel_code,
  output logic                      grant,
  output logic                      deny
);

  logic idx_valid;

  always_comb begin
    idx_valid = int'(idx) < int'(NUM_SLOTS);
    sel_code  = POL_NONE;
    for (int s = 0; s < int'(NUM_SLOTS); s++) begin
      if (int'(idx) == s) sel_code = slots[s].code;
    end
    grant = idx_valid && perm_allows(policy_perm(sel_code), sup, wr);
    deny  = !grant;
  end

endmodule

// File: rtl/periph_access_ctrl.sv
module periph_access_ctrl
  import pac_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] BASE_OFS = 8'h24,
  parameter int unsigned       NUM_REGS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             reg_err,
  input  logic [$clog2(NUM_REGS*SLOTS_PER_REG)-1:0] chk_idx,
  input  logic             chk_super,
  input  logic             chk_write,
  output logic             chk_grant,
  output logic             chk_deny
);

  localparam int unsigned NUM_SLOTS  = NUM_REGS * SLOTS_PER_REG;
  localparam int unsigned CHK_IDX_W  = $clog2(NUM_SLOTS);
  localparam int unsigned REG_IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                       addr_hit;
  logic [REG_IDX_W-1:0]       reg_idx;
  logic                       wr_hit;
  logic                       rd_hit;
  logic                       write_blocked;
  logic [NUM_REGS-1:0]        reg_locked;
  logic [NUM_REGS-1:0][REG_W-1:0] reg_img;
  pac_slot_t [NUM_SLOTS-1:0]  all_slots;
  logic [NUM_SLOTS-1:0]       lock_vec;
  logic [NUM_SLOTS*CODE_W-1:0] code_vec;
  logic [CODE_W-1:0]          chk_code;

  pac_addr_decode #(
    .ADDR_W   (ADDR_W),
    .BASE     (BASE_OFS),
    .NUM_REGS (NUM_REGS),
    .REG_IDX_W(REG_IDX_W)
  ) i_decode (
    .addr   (reg_addr),
    .hit    (addr_hit),
    .reg_idx(reg_idx)
  );

  assign wr_hit = reg_sel && reg_we && addr_hit;
  assign rd_hit = reg_sel && !reg_we && addr_hit;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic wr_this;
    pac_slot_t [SLOTS_PER_REG-1:0] slots_r;

    assign wr_this = wr_hit && (int'(reg_idx) == r);

    pac_policy_reg #(.SLOTS(SLOTS_PER_REG)) i_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_this),
      .wdata       (reg_wdata),
      .slots_o     (slots_r),
      .locked_any_o(reg_locked[r])
    );

    assign all_slots[r*SLOTS_PER_REG +: SLOTS_PER_REG] = slots_r;
    assign reg_img[r] = slots_r;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_flat
    assign lock_vec[s]                = all_slots[s].lock;
    assign code_vec[s*CODE_W +: CODE_W] = all_slots[s].code;
  end

  always_comb begin
    write_blocked = 1'b0;
    reg_rdata     = '0;
    for (int r = 0; r < int'(NUM_REGS); r++) begin
      if (int'(reg_idx) == r) begin
        write_blocked = wr_hit && reg_locked[r];
        if (rd_hit) reg_rdata = reg_img[r];
      end
    end
  end

  assign reg_err = write_blocked;

  pac_slot_check #(
    .NUM_SLOTS(NUM_SLOTS),
    .IDX_W    (CHK_IDX_W)
  ) i_check (
    .slots   (all_slots),
    .idx     (chk_idx),
    .sup     (chk_super),
    .wr      (chk_write),
    .sel_code(chk_code),
    .grant   (chk_grant),
    .deny    (chk_deny)
  );

endmodule

// File: rtl/pac_checker.sv
module pac_checker #(
  parameter int unsigned NUM_SLOTS = 6,
  parameter int unsigned IDX_W     = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_sel,
  input logic                   reg_we,
  input logic                   reg_err,
  input logic                   wr_hit,
  input logic                   rd_hit,
  input logic [NUM_SLOTS-1:0]   lock_vec,
  input logic [NUM_SLOTS*3-1:0] code_vec,
  input logic [IDX_W-1:0]       chk_idx,
  input logic                   chk_super,
  input logic                   chk_write,
  input logic [2:0]             chk_code,
  input logic                   chk_grant,
  input logic                   chk_deny
);

  // R9
  grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_grant != chk_deny);

  // R9
  idx_range_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(chk_idx) >= int'(NUM_SLOTS)) |-> chk_deny);

  // R8
  no_access_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_code == 3'b111) |-> chk_deny);

  // R8
  open_code_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(chk_idx) < int'(NUM_SLOTS)) && (chk_code == 3'b100 || chk_code == 3'b110))
      |-> chk_grant);

  // R8
  user_write_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_super && chk_write && chk_code inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b101})
      |-> chk_deny);

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_vec) & ~lock_vec) == '0));

  // R2
  read_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_we) |-> !reg_err);

  // R10
  err_only_decoded_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> wr_hit);

  // R2
  read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> (reg_sel && !reg_we));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hold
    // R4
    locked_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_vec[s]) |-> (code_vec[s*3 +: 3] == $past(code_vec[s*3 +: 3])));
  end

endmodule

bind periph_access_ctrl pac_checker #(
  .NUM_SLOTS(NUM_SLOTS),
  .IDX_W    (CHK_IDX_W)
) i_pac_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_sel  (reg_sel),
  .reg_we   (reg_we),
  .reg_err  (reg_err),
  .wr_hit   (wr_hit),
  .rd_hit   (rd_hit),
  .lock_vec (lock_vec),
  .code_vec (code_vec),
  .chk_idx  (chk_idx),
  .chk_super(chk_super),
  .chk_write(chk_write),
  .chk_code (chk_code),
  .chk_grant(chk_grant),
  .chk_deny (chk_deny)
);

// File: tb/test_periph_access_ctrl.sv
module test_periph_access_ctrl;

  // Permission nibble per code, code 7 in the top nibble:
  // bit3 sup read, bit2 sup write, bit1 user read, bit0 user write.
  localparam logic [31:0] PERM_TBL = 32'h0FEF_8A8C;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       reg_err;
  logic [2:0] chk_idx = '0;
  logic       chk_super = 1'b0;
  logic       chk_write = 1'b0;
  logic       chk_grant;
  logic       chk_deny;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] model [3];
  bit done = 1'b0;

  always #4 clk = ~clk;

  periph_access_ctrl i_periph_access_ctrl (
    .clk, .rst_n, .reg_sel, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .reg_err, .chk_idx, .chk_super, .chk_write, .chk_grant, .chk_deny
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit in_range(input logic [7:0] a);
    return (a >= 8'h24) && (a <= 8'h26);
  endfunction

  task automatic do_write(input string req, input logic [7:0] a,
                          input logic [7:0] d);
    logic exp_err;
    int r;
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    r = int'(a) - 'h24;
    exp_err = in_range(a) && (model[r][7] || model[r][3]);
    #1;
    chk(req, "write error", {7'd0, reg_err}, {7'd0, exp_err});
    @(posedge clk);
    if (in_range(a)) begin
      if (!model[r][3]) model[r][3:0] = d[3:0];
      if (!model[r][7]) model[r][7:4] = d[7:4];
    end
    #1;
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [7:0] a);
    logic [7:0] exp;
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    exp = in_range(a) ? model[int'(a) - 'h24] : 8'h00;
    #1;
    chk(req, "read data", reg_rdata, exp);
    chk(req, "read error", {7'd0, reg_err}, 8'h00);
    reg_sel = 1'b0;
  endtask

  task automatic read_all(input string req);
    for (int r = 0; r < 3; r++) do_read(req, 8'(8'h24 + r));
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 8; i++) begin
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < 2; w++) begin
          logic [2:0] code;
          logic [3:0] p;
          logic exp;
          code = (i % 2 == 0) ? model[i/2 % 3][2:0] : model[i/2 % 3][6:4];
          p = PERM_TBL[code*4 +: 4];
          exp = (i < 6) && (s == 1 ? (w == 1 ? p[2] : p[3])
                                   : (w == 1 ? p[0] : p[1]));
          chk_idx = 3'(i); chk_super = s[0]; chk_write = w[0];
          #1;
          chk(req, "grant", {7'd0, chk_grant}, {7'd0, exp});
          chk(req, "deny", {7'd0, chk_deny}, {7'd0, !exp});
        end
      end
    end
  endtask

  task automatic apply_reset;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int r = 0; r < 3; r++) model[r] = 8'h00;
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 3; r++) model[r] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents and default policy
    read_all("R1");
    sweep("R1");

    // R3 / R8: every slot sees every code, distinct codes per slot
    for (int k = 0; k < 8; k++) begin
      for (int r = 0; r < 3; r++) begin
        logic [2:0] c0, c1;
        c0 = 3'((2*r + k) % 8);
        c1 = 3'((2*r + 1 + k) % 8);
        do_write("R3", 8'(8'h24 + r), {1'b0, c1, 1'b0, c0});
      end
      read_all("R2");
      sweep("R8");
    end

    // R10: undecoded addresses
    do_write("R10", 8'h23, 8'hFF);
    do_write("R10", 8'h27, 8'hFF);
    do_write("R10", 8'h00, 8'h88);
    do_read("R10", 8'h23);
    do_read("R10", 8'h27);
    read_all("R10");

    // R7: lock and code in one write
    do_write("R7", 8'h24, 8'h0D);
    do_read("R7", 8'h24);
    chk("R7", "reg0 after lock write", model[0], 8'h0D);
    // R4 / R5: locked half held, unlocked half loads, error raised
    do_write("R4", 8'h24, 8'hFF);
    do_read("R5", 8'h24);
    chk("R5", "reg0 model", model[0], 8'hFD);
    // R6: clearing attempt fails
    do_write("R6", 8'h24, 8'h00);
    do_read("R6", 8'h24);
    do_write("R5", 8'h25, 8'hB2);
    do_write("R5", 8'h25, 8'h7F);
    do_read("R5", 8'h25);
    chk("R5", "reg1 model", model[1], 8'hBF);
    do_write("R4", 8'h26, 8'h88);
    do_write("R4", 8'h26, 8'h77);
    do_read("R4", 8'h26);
    sweep("R8");

    // R6: only reset clears locks
    apply_reset();
    read_all("R6");
    do_write("R6", 8'h26, 8'h44);
    do_read("R6", 8'h26);
    sweep("R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule